// File: doc/BRIEF.md
# Boot ROM Register Access Engine

This block sits between a host configuration-register port and an external boot ROM. Host software reaches the ROM through three registers: a 16-bit control/status register and two 32-bit mailboxes, called DATA0 and DATA1. A session opens only after an unlock key has been placed in DATA0. Inside a session the host asks for words to be fetched into a mailbox or stored from a mailbox. Each request has its own bit, and that bit clears itself when its transfer has finished.

The ROM side is a request port of the word-command kind. The block raises `rom_req` along with a command, a word address and write data. It holds all of them until the ROM returns a single-cycle `rom_ack`. Consecutive ROM words always pass through DATA0 and DATA1 in turn, and DATA0 comes first. An internal word address advances once per completed transfer and goes back to zero when the session closes.

A separate erase command is keyed by its own word in DATA0. It runs only while no session is open, and its busy bit stays set until the ROM acknowledges the erase.

Top module: `brom_access_engine`

## Requirements
- R1: Host select codes are 0 = control/status, 1 = DATA0, 2 = DATA1. The control/status register reads in bits 15:0 with zeros above. Bit 15 always mirrors `rom_present`. After reset every other bit and both mailboxes read zero.
- R2: Writing bit 0 = 1 while no session is open starts a session only if DATA0 holds 0x53524F4D. With any other value, no session starts and the result field (bits 6:4) becomes 2.
- R3: While a session is open, the result field reads 0 and bit 0 reads 1.
- R4: Writing 1 to bit 10 or bit 11 requests the next ROM word into DATA0 or DATA1 respectively. The bit reads 1 until the fetched word is in the mailbox, then reads 0.
- R5: Writing 1 to bit 8 or bit 9 stores DATA0 or DATA1 at the current word address and then clears. Each completed transfer advances the address by one. Transfers alternate DATA0, DATA1, DATA0 and so on, starting with DATA0 in every session.
- R6: Writing bit 0 = 0 closes the session and rewinds the word address to zero, so the next session begins at word 0.
- R7: While no session is open, writes to bits 8 to 11 have no effect: the bits read 0 and no read or write request reaches the ROM.
- R8: A request for the mailbox whose turn has not come stays pending and readable until that turn arrives. A mailbox with both a fetch and a store pending does the fetch first. No request is lost.
- R9: Closing a session sets the result field to 1 if at least one transfer completed during that session, and to 0 otherwise.
- R10: Writing bit 1 = 1 while no session is open issues an erase only if DATA0 holds 0x5A65726F. Bit 1 reads 1 until the ROM acknowledges the erase. An erased ROM returns 0xFFFFFFFF. With any other key the write has no effect.
- R11: `rom_req`, `rom_cmd` (0 = read, 1 = write, 2 = erase) and `rom_addr` stay steady from the rise of `rom_req` until the cycle in which `rom_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_wsel | input | 2 | Register selected for the write |
| host_wdata | input | 32 | Write data (control/status uses bits 15:0) |
| host_rsel | input | 2 | Register selected for the read |
| host_rdata | output | 32 | Read data, combinational from `host_rsel` |
| rom_present | input | 1 | High when a ROM is fitted |
| rom_req | output | 1 | ROM command request, held until acknowledge |
| rom_cmd | output | 2 | ROM command code |
| rom_addr | output | ADDR_W | ROM word address |
| rom_wdata | output | 32 | Word to store |
| rom_ack | input | 1 | One-cycle completion from the ROM |
| rom_rdata | input | 32 | Fetched word, valid with `rom_ack` |

## Verification
The properties assume that `rom_ack` arrives only while `rom_req` is high and lasts a single cycle. The responder in the bench counts latency only while a request is outstanding and drops the acknowledge at the next falling edge. The properties also assume that the host does not close a session while a transfer is in flight, so the address step always lands inside an open session. The bench therefore waits for every request bit to read zero before it writes bit 0 = 0. Unlock and erase keys are written to DATA0 before the control write that uses them.

// File: rtl/brom_pkg.sv
package brom_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'h5352_4F4D;
    localparam logic [31:0] ERASE_KEY  = 32'h5A65_726F;

    localparam logic [1:0] HSEL_CSR = 2'd0;
    localparam logic [1:0] HSEL_D0  = 2'd1;
    localparam logic [1:0] HSEL_D1  = 2'd2;

    localparam logic [2:0] RES_NONE   = 3'd0;
    localparam logic [2:0] RES_OK     = 3'd1;
    localparam logic [2:0] RES_LOCKED = 3'd2;

    localparam int CB_EN    = 0;
    localparam int CB_ERASE = 1;

    typedef enum logic [1:0] {
        ROP_READ  = 2'd0,
        ROP_WRITE = 2'd1,
        ROP_ERASE = 2'd2
    } rop_e;

    typedef struct packed {
        logic        valid;
        logic        slot;
        logic        is_get;
        logic        is_erase;
        logic [31:0] rdata;
    } fin_t;

    function automatic logic [15:0] csr_pack(
        input logic       present,
        input logic [1:0] get_p,
        input logic [1:0] set_p,
        input logic [2:0] res,
        input logic       erase_busy,
        input logic       en
    );
        return {present, 3'b000, get_p, set_p, 1'b0, res, 2'b00, erase_busy, en};
    endfunction

endpackage

// File: rtl/brom_host_regs.sv
module brom_host_regs
    import brom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [1:0]       host_wsel,
    input  logic [31:0]      host_wdata,
    input  logic [1:0]       host_rsel,
    output logic [31:0]      host_rdata,
    input  logic             rom_present,
    input  fin_t             fin,
    output logic             sess_en,
    output logic [1:0]       get_pend,
    output logic [1:0]       set_pend,
    output logic             erase_pend,
    output logic [1:0][31:0] mbox,
    output logic [2:0]       res_code
);

    logic             en_q, en_d;
    logic             erase_q, erase_d;
    logic             seen_q, seen_d;
    logic [2:0]       res_q, res_d;
    logic [1:0]       get_q, get_d;
    logic [1:0]       set_q, set_d;
    logic [1:0][31:0] data_q, data_d;
    logic             csr_wr;

    assign csr_wr = host_we && (host_wsel == HSEL_CSR);

    always_comb begin
        en_d    = en_q;
        erase_d = erase_q;
        seen_d  = seen_q;
        res_d   = res_q;
        get_d   = get_q;
        set_d   = set_q;
        data_d  = data_q;

        if (host_we && host_wsel == HSEL_D0) data_d[0] = host_wdata;
        if (host_we && host_wsel == HSEL_D1) data_d[1] = host_wdata;

        if (fin.valid) begin
            if (fin.is_erase) begin
                erase_d = 1'b0;
            end else begin
                seen_d = 1'b1;
                if (fin.is_get) begin
                    get_d[fin.slot]  = 1'b0;
                    data_d[fin.slot] = fin.rdata;
                end else begin
                    set_d[fin.slot] = 1'b0;
                end
            end
        end

        if (csr_wr) begin
            if (en_q) begin
                if (!host_wdata[CB_EN]) begin
                    en_d  = 1'b0;
                    res_d = seen_d ? RES_OK : RES_NONE;
                    get_d = 2'b00;
                    set_d = 2'b00;
                end else begin
                    get_d = get_d | host_wdata[11:10];
                    set_d = set_d | host_wdata[9:8];
                end
            end else if (!erase_q) begin
                if (host_wdata[CB_EN]) begin
                    if (data_q[0] == UNLOCK_KEY) begin
                        en_d   = 1'b1;
                        res_d  = RES_NONE;
                        seen_d = 1'b0;
                    end else begin
                        res_d = RES_LOCKED;
                    end
                end else if (host_wdata[CB_ERASE] && data_q[0] == ERASE_KEY) begin
                    erase_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            erase_q <= 1'b0;
            seen_q  <= 1'b0;
            res_q   <= RES_NONE;
            get_q   <= 2'b00;
            set_q   <= 2'b00;
            data_q  <= '0;
        end else begin
            en_q    <= en_d;
            erase_q <= erase_d;
            seen_q  <= seen_d;
            res_q   <= res_d;
            get_q   <= get_d;
            set_q   <= set_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        case (host_rsel)
            HSEL_CSR: host_rdata = {16'h0000,
                                    csr_pack(rom_present, get_q, set_q, res_q, erase_q, en_q)};
            HSEL_D0:  host_rdata = data_q[0];
            HSEL_D1:  host_rdata = data_q[1];
            default:  host_rdata = 32'h0000_0000;
        endcase
    end

    assign sess_en    = en_q;
    assign get_pend   = get_q;
    assign set_pend   = set_q;
    assign erase_pend = erase_q;
    assign mbox       = data_q;
    assign res_code   = res_q;

endmodule

// File: rtl/brom_rom_seq.sv
module brom_rom_seq
    import brom_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sess_en,
    input  logic [1:0]        get_pend,
    input  logic [1:0]        set_pend,
    input  logic              erase_pend,
    input  logic [1:0][31:0]  mbox,
    output logic              rom_req,
    output logic [1:0]        rom_cmd,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [31:0]       rom_wdata,
    input  logic              rom_ack,
    input  logic [31:0]       rom_rdata,
    output fin_t              fin
);

    logic              busy_q;
    rop_e              cmd_q;
    logic              slot_q;
    logic              turn_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       wdata_q;
    logic              turn_get, turn_set;

    assign turn_get = get_pend[turn_q];
    assign turn_set = set_pend[turn_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cmd_q   <= ROP_READ;
            slot_q  <= 1'b0;
            turn_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (busy_q) begin
            if (rom_ack) begin
                busy_q <= 1'b0;
                if (cmd_q != ROP_ERASE && sess_en) begin
                    addr_q <= addr_q + 1'b1;
                    turn_q <= ~turn_q;
                end
            end
        end else begin
            if (!sess_en) begin
                addr_q <= '0;
                turn_q <= 1'b0;
            end
            if (erase_pend) begin
                busy_q <= 1'b1;
                cmd_q  <= ROP_ERASE;
            end else if (sess_en && (turn_get || turn_set)) begin
                busy_q  <= 1'b1;
                cmd_q   <= turn_get ? ROP_READ : ROP_WRITE;
                slot_q  <= turn_q;
                wdata_q <= mbox[turn_q];
            end
        end
    end

    assign rom_req   = busy_q;
    assign rom_cmd   = cmd_q;
    assign rom_addr  = addr_q;
    assign rom_wdata = wdata_q;

    assign fin.valid    = busy_q && rom_ack;
    assign fin.slot     = slot_q;
    assign fin.is_get   = (cmd_q == ROP_READ);
    assign fin.is_erase = (cmd_q == ROP_ERASE);
    assign fin.rdata    = rom_rdata;

endmodule

// File: rtl/brom_access_engine.sv
module brom_access_engine
    import brom_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_wsel,
    input  logic [31:0]       host_wdata,
    input  logic [1:0]        host_rsel,
    output logic [31:0]       host_rdata,
    input  logic              rom_present,
    output logic              rom_req,
    output logic [1:0]        rom_cmd,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [31:0]       rom_wdata,
    input  logic              rom_ack,
    input  logic [31:0]       rom_rdata
);

    fin_t             fin;
    logic             sess_en;
    logic [1:0]       get_pend, set_pend;
    logic             erase_pend;
    logic [1:0][31:0] mbox;
    logic [2:0]       res_code;

    brom_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wsel  (host_wsel),
        .host_wdata (host_wdata),
        .host_rsel  (host_rsel),
        .host_rdata (host_rdata),
        .rom_present(rom_present),
        .fin        (fin),
        .sess_en    (sess_en),
        .get_pend   (get_pend),
        .set_pend   (set_pend),
        .erase_pend (erase_pend),
        .mbox       (mbox),
        .res_code   (res_code)
    );

    brom_rom_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sess_en   (sess_en),
        .get_pend  (get_pend),
        .set_pend  (set_pend),
        .erase_pend(erase_pend),
        .mbox      (mbox),
        .rom_req   (rom_req),
        .rom_cmd   (rom_cmd),
        .rom_addr  (rom_addr),
        .rom_wdata (rom_wdata),
        .rom_ack   (rom_ack),
        .rom_rdata (rom_rdata),
        .fin       (fin)
    );

endmodule

// File: rtl/brom_access_engine_chk.sv
module brom_access_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sess_en,
    input logic              rom_req,
    input logic              rom_ack,
    input logic [1:0]        rom_cmd,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [2:0]        res_code
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rom_req && !rom_ack |=> rom_req && $stable(rom_addr) && $stable(rom_cmd)); // R11

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        rom_req && rom_ack && rom_cmd != 2'd2 && sess_en
        |=> rom_addr == $past(rom_addr) + 1'b1); // R5

    AST_REWIND: assert property (@(posedge clk) disable iff (rst)
        !sess_en && !rom_req |=> rom_addr == '0); // R6

    AST_NO_XFER_CLOSED: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_req) && rom_cmd != 2'd2 |-> $past(sess_en)); // R7

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        sess_en |-> res_code == 3'd0); // R3

    AST_ERASE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        rom_req && rom_cmd == 2'd2 |-> !sess_en); // R10

endmodule

bind brom_access_engine brom_access_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sess_en (sess_en),
    .rom_req (rom_req),
    .rom_ack (rom_ack),
    .rom_cmd (rom_cmd),
    .rom_addr(rom_addr),
    .res_code(res_code)
);

// File: tb/sim_brom_access_engine.sv
`timescale 1ns/1ps
module sim_brom_access_engine;

    localparam logic [31:0] UNLOCK = 32'h5352_4F4D;
    localparam logic [31:0] EKEY   = 32'h5A65_726F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_wsel = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [1:0]  host_rsel = 2'd0;
    logic [31:0] host_rdata;
    logic        rom_present = 1'b1;
    logic        rom_req;
    logic [1:0]  rom_cmd;
    logic [15:0] rom_addr;
    logic [31:0] rom_wdata;
    logic        rom_ack = 1'b0;
    logic [31:0] rom_rdata = 32'd0;

    int checks = 0;
    int fails  = 0;
    int exp_ptr = 0;
    int req_count = 0;
    int lat_cnt = 0;
    logic [31:0] mem [64];
    logic [31:0] init_img [64];
    logic [31:0] v;

    always #5 clk = ~clk;

    brom_access_engine #(.ADDR_W(16)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_wsel(host_wsel),
        .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
        .rom_present(rom_present), .rom_req(rom_req), .rom_cmd(rom_cmd),
        .rom_addr(rom_addr), .rom_wdata(rom_wdata), .rom_ack(rom_ack),
        .rom_rdata(rom_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // ROM responder and per-clock reference comparison of the word address
    initial begin
        for (int i = 0; i < 64; i++) begin
            init_img[i] = (32'h0101_0101 * (i + 7)) ^ 32'hC3A5_0000;
            mem[i] = init_img[i];
        end
        forever begin
            @(negedge clk);
            rom_ack = 1'b0;
            if (rom_req && !rst) begin
                if (lat_cnt == 0) req_count++;
                if (rom_cmd != 2'd2) begin
                    checks++;
                    if (rom_addr !== exp_ptr[15:0]) begin
                        fails++;
                        $display("FAIL R11 R5 addr actual=%h expected=%h", rom_addr, exp_ptr[15:0]);
                    end
                end
                if (lat_cnt == ((rom_cmd == 2'd2) ? 12 : 3)) begin
                    lat_cnt = 0;
                    rom_ack = 1'b1;
                    case (rom_cmd)
                        2'd0: begin rom_rdata = mem[rom_addr[5:0]]; exp_ptr++; end
                        2'd1: begin mem[rom_addr[5:0]] = rom_wdata; exp_ptr++; end
                        default: for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
                    endcase
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_wsel = s; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] r);
        host_rsel = s;
        #1;
        r = host_rdata;
    endtask

    task automatic wait_clear(input string tag, input logic [31:0] mask);
        logic [31:0] r;
        for (int n = 0; n < 300; n++) begin
            rd(2'd0, r);
            if ((r & mask) == 0) return;
            @(negedge clk);
        end
        chk({tag, " bits never cleared"}, r & mask, 32'd0);
    endtask

    task automatic close_session();
        wr(2'd0, 32'h0000_8000);
        exp_ptr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and presence bit
        rd(2'd0, v); chk("R1 reset csr", v, 32'h0000_8000);
        rd(2'd1, v); chk("R1 reset data0", v, 32'd0);
        rom_present = 1'b0;
        rd(2'd0, v); chk("R1 absent csr", v, 32'h0000_0000);
        rom_present = 1'b1;

        // R2: wrong key keeps access closed, result 2
        wr(2'd1, 32'h1234_5678);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0, v); chk("R2 locked", v, 32'h0000_8020);

        // R7: request bits ignored while closed
        wr(2'd0, 32'h0000_0F00);
        repeat (10) @(negedge clk);
        rd(2'd0, v); chk("R7 bits read 0", v, 32'h0000_8020);
        chk("R7 no rom request", req_count, 0);

        // R3: unlock
        wr(2'd1, UNLOCK);
        wr(2'd0, 32'h0000_8001);
        rd(2'd0, v); chk("R3 session open", v, 32'h0000_8001);

        // R4: fetch into both mailboxes
        wr(2'd0, 32'h0000_8C01);
        wait_clear("R4", 32'h0000_0C00);
        rd(2'd0, v); chk("R4 bits cleared", v, 32'h0000_8001);
        rd(2'd1, v); chk("R4 data0 word0", v, init_img[0]);
        rd(2'd2, v); chk("R4 data1 word1", v, init_img[1]);

        // R5: alternation continues
        wr(2'd0, 32'h0000_8401);
        wait_clear("R5", 32'h0000_0400);
        rd(2'd1, v); chk("R5 data0 word2", v, init_img[2]);
        wr(2'd0, 32'h0000_8801);
        wait_clear("R5", 32'h0000_0800);
        rd(2'd2, v); chk("R5 data1 word3", v, init_img[3]);

        // R8: out-of-turn request held, then served in order
        wr(2'd0, 32'h0000_8801);
        repeat (20) @(negedge clk);
        rd(2'd0, v); chk("R8 held pending", v, 32'h0000_8801);
        wr(2'd0, 32'h0000_8401);
        wait_clear("R8", 32'h0000_0C00);
        rd(2'd1, v); chk("R8 data0 word4", v, init_img[4]);
        rd(2'd2, v); chk("R8 data1 word5", v, init_img[5]);

        // R9: success on close
        close_session();
        rd(2'd0, v); chk("R9 success", v, 32'h0000_8010);

        // R6: rewind to word 0
        wr(2'd1, UNLOCK);
        wr(2'd0, 32'h0000_8001);
        wr(2'd0, 32'h0000_8401);
        wait_clear("R6", 32'h0000_0400);
        rd(2'd1, v); chk("R6 rewind word0", v, init_img[0]);

        // R5 and R8: store both; turn is DATA1 so word1 <- DATA1, word2 <- DATA0
        wr(2'd1, 32'hAAAA_0001);
        wr(2'd2, 32'hBBBB_0002);
        wr(2'd0, 32'h0000_8301);
        wait_clear("R5", 32'h0000_0300);
        chk("R5 store word1", mem[1], 32'hBBBB_0002);
        chk("R8 store word2", mem[2], 32'hAAAA_0001);
        close_session();

        // R9: empty session gives result 0
        wr(2'd1, UNLOCK);
        wr(2'd0, 32'h0000_8001);
        close_session();
        rd(2'd0, v); chk("R9 empty session", v, 32'h0000_8000);

        // R10: wrong key, then erase
        wr(2'd1, 32'hDEAD_0000);
        wr(2'd0, 32'h0000_8002);
        rd(2'd0, v); chk("R10 no key", v, 32'h0000_8000);
        chk("R10 rom kept", mem[3], init_img[3]);
        wr(2'd1, EKEY);
        wr(2'd0, 32'h0000_8002);
        rd(2'd0, v); chk("R10 busy bit", v & 32'h2, 32'h2);
        wait_clear("R10", 32'h0000_0002);
        wr(2'd1, UNLOCK);
        wr(2'd0, 32'h0000_8001);
        wr(2'd0, 32'h0000_8C01);
        wait_clear("R10", 32'h0000_0C00);
        rd(2'd1, v); chk("R10 erased data0", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R10 erased data1", v, 32'hFFFF_FFFF);
        close_session();

        repeat (5) @(negedge clk);
        summary();
    end

endmodule